// File: doc/BRIEF.md
# Transmit Dominant Time-out Guard

This block sits between the host's transmit line and the control input of a single-wire bus driver. A low level on the transmit line asks for the bus to be pulled dominant; a high level, which is also the idle default, leaves it recessive. The guard passes that request to the driver only while the mode controller grants transmission. It also watches how long the driver has been held on. Once the on time reaches a limit, counted in microsecond ticks, the driver is forced off and a time-out flag is raised.

The time-out is latched. A rising edge on the transmit line does not clear it on its own. The line has to stay high for a qualified number of ticks with no break, and only then does the guard return to idle and accept a new dominant request. Removing the transmit grant clears the driver output and the flag in the same cycle, and it also discards all timer state.

Five states make up the control: `ST_OFF` (transmission not granted), `ST_IDLE` (granted, line high), `ST_DRIVE` (driver on, dominant timer running), `ST_LOCKED` (timed out, line low) and `ST_QUALIFY` (timed out, line high, release timer running). The named transitions are: grant lost (any state to `ST_OFF`), grant gained (`ST_OFF` to `ST_IDLE`), start (`ST_IDLE` to `ST_DRIVE` on a low line), stop (`ST_DRIVE` to `ST_IDLE` on a high line), expire (`ST_DRIVE` to `ST_LOCKED` when the limit is reached), line up (`ST_LOCKED` to `ST_QUALIFY`), glitch (`ST_QUALIFY` to `ST_LOCKED` on a low line) and release (`ST_QUALIFY` to `ST_IDLE` when the release time is met).

Top module: `txd_dom_guard`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `drv_on` and `timeout_flag` are both 0.
- R2: With `tx_enable` high and no time-out, a low `txd_sync` seen at a clock edge in the idle state turns `drv_on` to 1 for the following cycle.
- R3: While driving, a high `txd_sync` seen at a clock edge turns `drv_on` to 0 for the following cycle and restarts the dominant count from zero.
- R4: Once `DOM_LIMIT_US` ticks of `us_tick` have been seen at clock edges in the driving state with `txd_sync` low, `drv_on` goes to 0 and `timeout_flag` goes to 1 on the next cycle. The driver is never on across `DOM_LIMIT_US` tick edges.
- R5: While `timeout_flag` is 1, a low `txd_sync` never turns `drv_on` on.
- R6: While timed out, a high run of `txd_sync` that covers fewer than `RELEASE_US` ticks and is followed by a low level leaves `timeout_flag` at 1 and `drv_on` at 0. The release count starts again from zero at the next high run.
- R7: While timed out, the flag clears after `txd_sync` has been high without a break across `RELEASE_US` tick edges. That count starts at the first edge after the edge that saw the line go high. A later low level then drives the bus again as in R2.
- R8: A low `tx_enable` forces `drv_on` and `timeout_flag` to 0 in that same cycle, and clears all timer and time-out state. After the grant returns, `drv_on` stays 0 for at least the first cycle.
- R9: When the final dominant tick and the removal of `tx_enable` fall in the same cycle, the grant removal wins: the flag stays 0 and no time-out is remembered after re-enable.
- R10: When the final release tick and a falling `txd_sync` fall in the same cycle, the low level wins: the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_sync | input | 1 | Synchronized transmit line; 0 requests dominant |
| tx_enable | input | 1 | Transmission granted by the mode controller |
| us_tick | input | 1 | One-cycle strobe each microsecond |
| drv_on | output | 1 | Bus driver on (bus dominant) |
| timeout_flag | output | 1 | Dominant time-out latched |

## Verification
There are two same-cycle collisions to exercise. The first is the last dominant tick arriving in the cycle that `tx_enable` drops. The second is the last release tick arriving in the cycle that `txd_sync` falls. The bench watches its reference counters and creates each collision on the exact cycle: it drops the grant, or pulls the line low, at the moment the model is one tick from its limit and a tick is being presented. It then judges that the grant loss leaves no time-out behind after re-enable, and that the low line keeps the flag set.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_IDLE    = 3'd1,
        ST_DRIVE   = 3'd2,
        ST_LOCKED  = 3'd3,
        ST_QUALIFY = 3'd4
    } guard_state_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/txg_tick_counter.sv
module txg_tick_counter #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    import txg_pkg::*;

    localparam int unsigned W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;
    logic         at_last;

    assign at_last = (cnt_q == LAST);
    assign done    = run && tick && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (at_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/txg_fsm.sv
module txg_fsm (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  txd,
    input  logic                  dom_done,
    input  logic                  rel_done,
    output txg_pkg::guard_state_e state,
    output logic                  dom_run,
    output logic                  rel_run
);
    import txg_pkg::*;

    guard_state_e state_q;
    guard_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_IDLE;
                ST_IDLE:    if (!txd) state_d = ST_DRIVE;
                ST_DRIVE: begin
                    if (txd)           state_d = ST_IDLE;
                    else if (dom_done) state_d = ST_LOCKED;
                end
                ST_LOCKED:  if (txd) state_d = ST_QUALIFY;
                ST_QUALIFY: begin
                    if (!txd)          state_d = ST_LOCKED;
                    else if (rel_done) state_d = ST_IDLE;
                end
                default:    state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        dom_run = 1'b0;
        rel_run = 1'b0;
        unique case (state_q)
            ST_DRIVE:   dom_run = en && !txd;
            ST_QUALIFY: rel_run = en && txd;
            default: begin
                dom_run = 1'b0;
                rel_run = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
    parameter int unsigned DOM_LIMIT_US = 10000,
    parameter int unsigned RELEASE_US   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_sync,
    input  logic tx_enable,
    input  logic us_tick,
    output logic drv_on,
    output logic timeout_flag
);
    import txg_pkg::*;

    guard_state_e state;
    logic         dom_run;
    logic         rel_run;
    logic [1:0]   run_vec;
    logic [1:0]   done_vec;

    txg_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_enable),
        .txd      (txd_sync),
        .dom_done (done_vec[0]),
        .rel_done (done_vec[1]),
        .state    (state),
        .dom_run  (dom_run),
        .rel_run  (rel_run)
    );

    assign run_vec = {rel_run, dom_run};

    for (genvar g = 0; g < 2; g++) begin : g_timer
        localparam int unsigned LIM = (g == 0) ? DOM_LIMIT_US : RELEASE_US;
        txg_tick_counter #(.LIMIT(LIM)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run_vec[g]),
            .tick  (us_tick),
            .done  (done_vec[g])
        );
    end

    always_comb begin
        drv_on       = 1'b0;
        timeout_flag = 1'b0;
        unique case (state)
            ST_DRIVE:   drv_on       = tx_enable;
            ST_LOCKED,
            ST_QUALIFY: timeout_flag = tx_enable;
            default: begin
                drv_on       = 1'b0;
                timeout_flag = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/txg_checker.sv
module txg_checker #(
    parameter int unsigned DOM_LIMIT_US = 10000,
    parameter int unsigned RELEASE_US   = 10
) (
    input logic clk,
    input logic rst_n,
    input logic txd_sync,
    input logic tx_enable,
    input logic us_tick,
    input logic drv_on,
    input logic timeout_flag
);
    int unsigned on_ticks_q;
    int unsigned hi_ticks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_ticks_q <= 0;
            hi_ticks_q <= 0;
        end else begin
            if (!drv_on)       on_ticks_q <= 0;
            else if (us_tick)  on_ticks_q <= on_ticks_q + 1;
            if (!(timeout_flag && txd_sync)) hi_ticks_q <= 0;
            else if (us_tick)                hi_ticks_q <= hi_ticks_q + 1;
        end
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_on) |-> $past(!txd_sync && tx_enable));

    assert_high_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_on && txd_sync) |=> !drv_on);

    assert_on_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drv_on |-> (on_ticks_q < DOM_LIMIT_US));

    assert_flag_from_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> $past(drv_on));

    assert_flag_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |-> !drv_on);

    assert_low_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !txd_sync) |=> (timeout_flag || !tx_enable));

    assert_release_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(timeout_flag) && tx_enable) |-> (hi_ticks_q >= RELEASE_US));

    assert_regrant_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_enable) |-> (!drv_on && !timeout_flag));

endmodule

bind txd_dom_guard txg_checker #(
    .DOM_LIMIT_US (DOM_LIMIT_US),
    .RELEASE_US   (RELEASE_US)
) i_txg_checker (.*);

// File: tb/test_txd_dom_guard.sv
module test_txd_dom_guard;

    localparam int LIM = 20;
    localparam int REL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd_sync = 1'b1;
    logic tx_enable = 1'b0;
    logic us_tick = 1'b0;
    logic drv_on;
    logic timeout_flag;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int tcnt = 0;
    bit tick_en = 1'b1;
    bit finished = 1'b0;

    // reference model state
    bit m_live, m_drive, m_latched, m_hi;
    int m_low, m_high;

    always #10 clk = ~clk;

    txd_dom_guard #(.DOM_LIMIT_US(LIM), .RELEASE_US(REL)) i_txd_dom_guard (
        .clk(clk), .rst_n(rst_n), .txd_sync(txd_sync), .tx_enable(tx_enable),
        .us_tick(us_tick), .drv_on(drv_on), .timeout_flag(timeout_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_live = 0; m_drive = 0; m_latched = 0; m_hi = 0; m_low = 0; m_high = 0;
        end else if (!tx_enable) begin
            m_live = 0; m_drive = 0; m_latched = 0; m_hi = 0; m_low = 0; m_high = 0;
        end else if (!m_live) begin
            m_live = 1;
        end else if (!m_latched) begin
            if (m_drive) begin
                if (txd_sync) begin
                    m_drive = 0; m_low = 0;
                end else if (us_tick) begin
                    m_low++;
                    if (m_low == LIM) begin
                        m_latched = 1; m_drive = 0; m_low = 0;
                    end
                end
            end else if (!txd_sync) begin
                m_drive = 1; m_low = 0;
            end
        end else begin
            if (!txd_sync) begin
                m_hi = 0; m_high = 0;
            end else if (!m_hi) begin
                m_hi = 1; m_high = 0;
            end else if (us_tick) begin
                m_high++;
                if (m_high == REL) begin
                    m_latched = 0; m_hi = 0; m_high = 0;
                end
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            check(drv_on === (tx_enable && m_drive), "R2 drv_on vs model",
                  int'(drv_on), int'(tx_enable && m_drive));
            check(timeout_flag === (tx_enable && m_latched), "R4 timeout_flag vs model",
                  int'(timeout_flag), int'(tx_enable && m_latched));
        end
    end

    task automatic step();
        @(negedge clk);
        us_tick = tick_en && (tcnt % 3 == 0);
        tcnt++;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic probe();
        #3;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        // R1 reset
        steps(3);
        probe();
        check(drv_on == 0 && timeout_flag == 0, "R1 reset outputs", int'(drv_on), 0);
        rst_n = 1'b1;
        tx_enable = 1'b1;
        step(); probe();
        check(drv_on == 0 && timeout_flag == 0, "R1 first cycle", int'(timeout_flag), 0);
        steps(2);

        // R2 start driving
        txd_sync = 1'b0;
        step(); probe();
        check(drv_on == 1, "R2 dominant request", int'(drv_on), 1);
        steps(10);
        // R3 line high stops driver
        txd_sync = 1'b1;
        step(); probe();
        check(drv_on == 0, "R3 recessive request", int'(drv_on), 0);
        // R3 count restarted: low for LIM-1 ticks must not time out
        txd_sync = 1'b0;
        steps(3 * (LIM - 1));
        probe();
        check(drv_on == 1 && timeout_flag == 0, "R3 timer restarted", int'(timeout_flag), 0);

        // R4 time-out
        for (int i = 0; i < 20 && !timeout_flag; i++) step();
        probe();
        check(timeout_flag == 1 && drv_on == 0, "R4 time-out latched", int'(timeout_flag), 1);
        // R5 low keeps driver off
        steps(30); probe();
        check(drv_on == 0, "R5 no drive while timed out", int'(drv_on), 0);

        // R6 short high then low
        txd_sync = 1'b1;
        steps(3 * (REL - 2));
        txd_sync = 1'b0;
        steps(5); probe();
        check(timeout_flag == 1 && drv_on == 0, "R6 short high ignored", int'(timeout_flag), 1);

        // R10 release completion collides with falling line
        txd_sync = 1'b1;
        for (int i = 0; i < 60; i++) begin
            step();
            if (m_hi && m_high == REL - 1 && us_tick) break;
        end
        txd_sync = 1'b0;
        steps(2); probe();
        check(timeout_flag == 1, "R10 low beats last release tick", int'(timeout_flag), 1);

        // R7 full release, then drive again
        txd_sync = 1'b1;
        steps(3 * REL + 6); probe();
        check(timeout_flag == 0, "R7 flag released", int'(timeout_flag), 0);
        txd_sync = 1'b0;
        step(); probe();
        check(drv_on == 1, "R7 drive after release", int'(drv_on), 1);

        // R8 grant removal clears immediately
        steps(4);
        tx_enable = 1'b0;
        probe();
        check(drv_on == 0, "R8 same-cycle driver off", int'(drv_on), 0);
        steps(3);
        tx_enable = 1'b1;
        step(); probe();
        check(drv_on == 0, "R8 quiet after regrant", int'(drv_on), 0);
        // drive into time-out then drop grant
        for (int i = 0; i < 200 && !timeout_flag; i++) step();
        tx_enable = 1'b0;
        probe();
        check(timeout_flag == 0, "R8 flag cleared same cycle", int'(timeout_flag), 0);
        steps(2);
        txd_sync = 1'b1;
        tx_enable = 1'b1;
        steps(3); probe();
        check(timeout_flag == 0, "R8 time-out forgotten", int'(timeout_flag), 0);

        // R9 final dominant tick collides with grant removal
        txd_sync = 1'b0;
        for (int i = 0; i < 200; i++) begin
            step();
            if (m_drive && m_low == LIM - 1 && us_tick) break;
        end
        tx_enable = 1'b0;
        steps(2);
        txd_sync = 1'b1;
        tx_enable = 1'b1;
        steps(3); probe();
        check(timeout_flag == 0 && drv_on == 0, "R9 grant loss beats expiry", int'(timeout_flag), 0);

        // ticks stopped: no time-out however long the line is low
        tick_en = 1'b0;
        txd_sync = 1'b0;
        steps(200); probe();
        check(drv_on == 1 && timeout_flag == 0, "R4 counts ticks not cycles", int'(drv_on), 1);
        tick_en = 1'b1;
        steps(3 * LIM + 6); probe();
        check(timeout_flag == 1, "R4 expiry with ticks", int'(timeout_flag), 1);

        steps(4);
        finish_run();
    end

endmodule